// File: doc/BRIEF.md
# Serial ADC Control-Byte Interface

This block is the digital front end, on the device side, of a two-channel 8-bit serial analog-to-digital converter. It sits behind four serial pins: an active-low chip select, a serial clock, a serial data input and a serial data output. A host talks to it as an SPI master in mode 0. The block runs on a fast system clock. It brings the serial pins into that clock domain and turns serial-clock edges into single-cycle events.

Once chip select falls, the block discards zeros on the data input until the first one arrives. That one is the start bit and becomes the most significant bit of an 8-bit control byte. While the byte shifts in, the block issues a track strobe and then a convert strobe to the successive-approximation core, which lies outside this block. The strobes are timed from serial-clock falling edges, counted from the start bit. When the core reports a finished conversion, the block takes the parallel result and sends it back MSB first. The result goes out either as plain binary or in two's-complement form, depending on a bit of the control byte.

Top module: `sadc_ctl_if`

## Requirements
- R1: The data input is sampled only on serial-clock rising edges while chip select is low. Clock activity while chip select is high has no effect on the next captured byte.
- R2: After chip select falls, zeros are discarded. The first one sampled is bit 7 of the control byte, and the following seven rising edges supply bits 6 down to 0. `ctrl_o` then holds the byte, and `ctrl_vld_o` pulses once.
- R3: Control-byte bit 3 selects the conversion clock mode: 0 means external (serial clock driven), 1 means internal.
- R4: `dout_en` is low while chip select is high. While chip select is low, `dout_en` is high and `dout` is driven low until the first result bit is presented.
- R5: `track_o` pulses exactly once per transaction, on the falling edge of the fourth serial clock of the byte. The start-bit clock counts as the first.
- R6: `convert_o` pulses exactly once per transaction. In external mode it falls on the sixth clock's falling edge; in internal mode it falls on the eighth clock's falling edge. It never coincides with `track_o`.
- R7: A `done_i` pulse after the byte is complete loads `result_i`. The first bit (bit 7) appears on `dout` at the next serial-clock falling edge. Each later falling edge presents the next lower bit, and zeros follow bit 0.
- R8: Control-byte bit 2 selects the output format. With 0 (unipolar) the sent byte equals `result_i`. With 1 (bipolar) it is `result_i` with bit 7 inverted, which turns the core's offset-binary code into two's complement.
- R9: Chip select rising at any point aborts the transaction: no further strobes or byte-valid pulses follow, and the next transaction hunts for a new start bit.
- R10: A `done_i` pulse that arrives before the control byte is complete is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| done_i | input | 1 | Conversion-finished strobe from the core |
| result_i | input | 8 | Raw conversion result from the core (offset binary) |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Output-driver enable; low means high impedance |
| ctrl_o | output | 8 | Captured control byte |
| ctrl_vld_o | output | 1 | One-cycle pulse when the control byte is complete |
| track_o | output | 1 | One-cycle strobe: begin tracking the input |
| convert_o | output | 1 | One-cycle strobe: end acquisition, start conversion |

## Verification
The bench varies the number of leading zeros and checks three things: the captured byte, and the falling-edge index at which each strobe fires. A design that counted from chip select rather than from the start bit would place the strobes early, and the byte would come out shifted. Both output formats are read back in both clock modes. Swapping the mode bit or missing the MSB inversion shows up as a convert strobe at the wrong edge or a wrong byte. Two further cases target the abort path and stray activity. One aborts mid-byte, runs serial clocks with chip select high, and sends an early `done_i`. A design that kept stale counter or shifter state, or sampled with chip select high, would then mis-capture the next byte or return a stale result.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int BYTE_W       = 8;
    localparam int CNT_W        = $clog2(BYTE_W + 1);
    localparam int TRACK_CLK    = 4;
    localparam int CONV_CLK_EXT = 6;
    localparam int CONV_CLK_INT = BYTE_W;
    localparam int MODE_BIT     = 3;
    localparam int POL_BIT      = 2;
    // position of the mode bit in the shifter once CONV_CLK_EXT bits are in
    localparam int MODE_IDX     = MODE_BIT - (BYTE_W - CONV_CLK_EXT);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SHIFT,
        ST_WAIT,
        ST_XFER
    } phase_e;

    typedef struct packed {
        logic act;    // chip select low (synchronized)
        logic start;  // chip select just fell
        logic rise;   // serial clock rising edge while selected
        logic fall;   // serial clock falling edge while selected
        logic sdi;    // synchronized data input
    } ser_evt_t;

    function automatic logic [BYTE_W-1:0] fmt_result(
        input logic [BYTE_W-1:0] raw,
        input logic              bipolar
    );
        return bipolar ? {~raw[BYTE_W-1], raw[BYTE_W-2:0]} : raw;
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync
    import sadc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     din,
    output ser_evt_t evt
);
    localparam int SIGS = 3;
    localparam logic [SIGS-1:0] RST_V = 3'b100;

    logic [SYNC_STAGES-1:0][SIGS-1:0] stage;
    logic prev_cs_n;
    logic prev_sclk;
    logic cs_s, sclk_s, din_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= {SYNC_STAGES{RST_V}};
            prev_cs_n <= 1'b1;
            prev_sclk <= 1'b0;
        end else begin
            stage[0] <= {cs_n, sclk, din};
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
            prev_cs_n <= cs_s;
            prev_sclk <= sclk_s;
        end
    end

    assign {cs_s, sclk_s, din_s} = stage[SYNC_STAGES-1];

    always_comb begin
        evt.act   = ~cs_s;
        evt.start = prev_cs_n & ~cs_s;
        evt.rise  = ~cs_s & sclk_s & ~prev_sclk;
        evt.fall  = ~cs_s & ~sclk_s & prev_sclk;
        evt.sdi   = din_s;
    end

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ser_evt_t          evt,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              ctrl_vld_o,
    output logic              track_o,
    output logic              convert_o,
    output logic              bipolar_o,
    output logic              xfer_o
);
    phase_e             phase;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  nxt_byte;

    assign nxt_byte = {shreg[BYTE_W-2:0], evt.sdi};

    always_ff @(posedge clk) begin
        if (rst || !evt.act) begin
            phase      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            ctrl_vld_o <= 1'b0;
            track_o    <= 1'b0;
            convert_o  <= 1'b0;
        end else begin
            ctrl_vld_o <= 1'b0;
            track_o    <= 1'b0;
            convert_o  <= 1'b0;
            unique case (phase)
                ST_IDLE: begin
                    if (evt.start) phase <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (evt.rise && evt.sdi) begin
                        shreg <= BYTE_W'(1);
                        cnt   <= CNT_W'(1);
                        phase <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (evt.rise) begin
                        shreg <= nxt_byte;
                        cnt   <= cnt + CNT_W'(1);
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            ctrl_vld_o <= 1'b1;
                            phase      <= nxt_byte[MODE_BIT] ? ST_WAIT : ST_XFER;
                        end
                    end else if (evt.fall) begin
                        if (cnt == CNT_W'(TRACK_CLK)) track_o <= 1'b1;
                        if (cnt == CNT_W'(CONV_CLK_EXT) && !shreg[MODE_IDX])
                            convert_o <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (evt.fall) begin
                        convert_o <= 1'b1;
                        phase     <= ST_XFER;
                    end
                end
                ST_XFER: ;
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign ctrl_o    = shreg;
    assign bipolar_o = shreg[POL_BIT];
    assign xfer_o    = (phase == ST_XFER) || (phase == ST_WAIT);

    p_vld_msb_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_vld_o |-> ctrl_o[BYTE_W-1]);

    p_track_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        track_o |=> !track_o);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(track_o && convert_o));

    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(evt.act) |=> (!track_o && !convert_o && !ctrl_vld_o));

endmodule

// File: rtl/sadc_out.sv
module sadc_out
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic              fall_i,
    input  logic              load_ok_i,
    input  logic              bipolar_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] result_i,
    output logic              dout,
    output logic              dout_en
);
    logic [BYTE_W-1:0] hold;
    logic [BYTE_W-1:0] sr;
    logic              pend;
    logic              dout_r;

    always_ff @(posedge clk) begin
        if (rst || !act_i) begin
            hold   <= '0;
            sr     <= '0;
            pend   <= 1'b0;
            dout_r <= 1'b0;
        end else begin
            if (fall_i) begin
                if (pend) begin
                    dout_r <= hold[BYTE_W-1];
                    sr     <= {hold[BYTE_W-2:0], 1'b0};
                    pend   <= 1'b0;
                end else begin
                    dout_r <= sr[BYTE_W-1];
                    sr     <= {sr[BYTE_W-2:0], 1'b0};
                end
            end
            if (done_i && load_ok_i) begin
                hold <= fmt_result(result_i, bipolar_i);
                pend <= 1'b1;
            end
        end
    end

    assign dout    = dout_r;
    assign dout_en = act_i;

    p_abort_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(act_i) |=> !pend);

    p_early_done_r10: assert property (@(posedge clk) disable iff (rst)
        (done_i && !load_ok_i && !pend) |=> !pend);

endmodule

// File: rtl/sadc_ctl_if.sv
module sadc_ctl_if
    import sadc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] result_i,
    output logic              dout,
    output logic              dout_en,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              ctrl_vld_o,
    output logic              track_o,
    output logic              convert_o
);
    ser_evt_t evt;
    logic     bipolar;
    logic     xfer;

    sadc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .din  (din),
        .evt  (evt)
    );

    sadc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .ctrl_o     (ctrl_o),
        .ctrl_vld_o (ctrl_vld_o),
        .track_o    (track_o),
        .convert_o  (convert_o),
        .bipolar_o  (bipolar),
        .xfer_o     (xfer)
    );

    sadc_out u_out (
        .clk       (clk),
        .rst       (rst),
        .act_i     (evt.act),
        .fall_i    (evt.fall),
        .load_ok_i (xfer),
        .bipolar_i (bipolar),
        .done_i    (done_i),
        .result_i  (result_i),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    p_hiz_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_en);

endmodule

// File: tb/sadc_ctl_if_tb.sv
module sadc_ctl_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, done_i = 1'b0;
    logic [7:0] result_i = '0;
    logic dout, dout_en, ctrl_vld_o, track_o, convert_o;
    logic [7:0] ctrl_o;

    int checks = 0, failures = 0;
    int fall_idx = 0;
    int track_cnt = 0, conv_cnt = 0, vld_cnt = 0;
    int track_at = -1, conv_at = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_ctl_if u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .done_i(done_i), .result_i(result_i), .dout(dout), .dout_en(dout_en),
        .ctrl_o(ctrl_o), .ctrl_vld_o(ctrl_vld_o), .track_o(track_o),
        .convert_o(convert_o)
    );

    always @(posedge clk) begin
        if (track_o)    begin track_cnt++; track_at = fall_idx; end
        if (convert_o)  begin conv_cnt++;  conv_at  = fall_idx; end
        if (ctrl_vld_o) vld_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clr_mon();
        track_cnt = 0; conv_cnt = 0; vld_cnt = 0;
        track_at = -1; conv_at = -1; fall_idx = 0;
    endtask

    task automatic clock_bit(input logic b);
        din = b;
        wait_half();
        sclk = 1'b1;
        wait_half();
        sclk = 1'b0;
        fall_idx++;
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Full transaction: leading zeros, control byte, result readback.
    task automatic run_txn(input int zeros, input logic [7:0] ctrl,
                           input logic [7:0] res, input bit early_done);
        logic [7:0] got;
        logic [7:0] exp;
        logic       tail;
        clr_mon();
        @(negedge clk) cs_n = 1'b0;
        wait_half();
        chk("R4 dout_en low-cs", int'(dout_en), 1);
        chk("R4 dout low", int'(dout), 0);
        if (early_done) begin
            @(negedge clk) begin done_i = 1'b1; result_i = 8'hA5; end
            @(negedge clk) done_i = 1'b0;
        end
        for (int i = 0; i < zeros; i++) clock_bit(1'b0);
        for (int i = 7; i >= 0; i--) clock_bit(ctrl[i]);
        wait_half();
        chk("R2 ctrl byte", int'(ctrl_o), int'(ctrl));
        chk("R2 vld once", vld_cnt, 1);
        chk("R5 track count", track_cnt, 1);
        chk("R5 track edge", track_at, zeros + 4);
        chk("R6 convert count", conv_cnt, 1);
        chk("R3 R6 convert edge", conv_at, zeros + (ctrl[3] ? 8 : 6));
        if (!early_done) begin
            @(negedge clk) begin done_i = 1'b1; result_i = res; end
            @(negedge clk) done_i = 1'b0;
            exp = ctrl[2] ? {~res[7], res[6:0]} : res;
        end else begin
            exp = 8'h00;
        end
        // one clock before the MSB appears
        clock_bit(1'b0);
        for (int i = 7; i >= 0; i--) begin
            wait_half();
            got[i] = dout;
            sclk = 1'b1;
            wait_half();
            sclk = 1'b0;
        end
        wait_half();
        tail = dout;
        if (early_done) chk("R10 early done ignored", int'(got), 0);
        else            chk("R7 R8 result byte", int'(got), int'(exp));
        chk("R7 zero after lsb", int'(tail), 0);
        chk("R6 no extra convert", conv_cnt, 1);
        @(negedge clk) cs_n = 1'b1;
        wait_half();
        chk("R4 dout_en high-z", int'(dout_en), 0);
    endtask

    task automatic test_reset();
        chk("R4 reset dout_en", int'(dout_en), 0);
        chk("R5 reset track", int'(track_o), 0);
        chk("R6 reset convert", int'(convert_o), 0);
        chk("R2 reset vld", int'(ctrl_vld_o), 0);
    endtask

    task automatic test_abort();
        clr_mon();
        @(negedge clk) cs_n = 1'b0;
        wait_half();
        clock_bit(1'b0);
        clock_bit(1'b1);
        clock_bit(1'b0);
        clock_bit(1'b1);
        @(negedge clk) cs_n = 1'b1;
        wait_half();
        clock_bit(1'b1);
        clock_bit(1'b1);
        wait_half();
        chk("R9 no track after abort", track_cnt, 0);
        chk("R9 no convert after abort", conv_cnt, 0);
        chk("R9 no vld after abort", vld_cnt, 0);
    endtask

    task automatic test_idle_clocks();
        clr_mon();
        for (int i = 0; i < 10; i++) clock_bit(1'b1);
        wait_half();
        chk("R1 no vld while cs high", vld_cnt, 0);
        chk("R1 no track while cs high", track_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        test_reset();
        run_txn(0, 8'b1000_0000, 8'h3C, 1'b0);   // external, unipolar
        run_txn(3, 8'b1000_0100, 8'h3C, 1'b0);   // external, bipolar
        run_txn(5, 8'b1001_1000, 8'hC3, 1'b0);   // internal, unipolar
        run_txn(1, 8'b1010_1101, 8'h81, 1'b0);   // internal, bipolar
        test_abort();
        run_txn(2, 8'b1110_0111, 8'h7E, 1'b0);   // R9 fresh hunt after abort
        test_idle_clocks();
        run_txn(4, 8'b1000_0001, 8'h5A, 1'b0);   // R1 idle clocks left no trace
        run_txn(2, 8'b1000_0000, 8'h00, 1'b1);   // R10 early done
        finish_up();
    end

endmodule